// File: doc/BRIEF.md
# Wake-Up Tone Qualifier

This controller sits behind the comparator of an RF wake-up receiver and decides whether a digitised tone is a real wake-up request before it powers a large transceiver. It runs from an always-on slow clock. It measures the spacing between successive rising edges of the comparator bit and compares each spacing with a programmable period window. When a configured number of consecutive spacings fall inside the window, it raises the transceiver enable. Once one spacing has been accepted, the window widens by a programmable margin. This lets a tone that drifts in frequency still qualify.

While no tone is present the controller hibernates with its sampling oscillator enable low. A rising comparator edge wakes it. It then waits a fixed settle interval before it starts measuring. A down-counting watchdog brings it back to hibernation if a tone stops or never qualifies. The transceiver enable stays high until the host pulses a done input. All configuration inputs are captured only while hibernating.

States: HIBERNATE (oscillator off, configuration tracked), SETTLE (fixed count of ticks, edges ignored), ARM (waiting for the edge that starts measurement), MEASURE (each edge closes one period and opens the next), AWAKE (transceiver enabled). Transitions: HIBERNATE→SETTLE on a rising edge. SETTLE→ARM when the settle count ends. ARM→MEASURE on a rising edge. MEASURE→AWAKE when the run of accepted periods reaches the target. AWAKE→HIBERNATE on done. SETTLE, ARM or MEASURE→HIBERNATE when the watchdog expires.

Top module: `wkup_validator`

## Requirements
- R1: After reset, both `trx_en` and `osc_en` are low and the controller is hibernating.
- R2: In hibernation, a rising edge of `comp_in` that is first sampled high at clock edge k makes `osc_en` high after edge k+2. Before that, `osc_en` stays low.
- R3: Rising edges that reach the state machine within SETTLE_TICKS edges of the wake edge are ignored. The first edge after that only starts the measurement.
- R4: A period is the number of clock cycles between two successive synchronised rising edges. While the run count is zero, it is accepted when `cfg_min_per` <= period <= `cfg_max_per`.
- R5: When the run count is one or more, the bounds become `cfg_min_per - cfg_margin` (floored at 0) and `cfg_max_per + cfg_margin` (capped at the counter maximum).
- R6: A period outside the current window clears the run count to zero. The same edge starts the next period.
- R7: At the edge where the run count reaches `cfg_cycles` (a value of 0 acts as 1), `trx_en` rises and `osc_en` falls in the same cycle. The two are never high together.
- R8: `trx_en` stays high until `done_clr` is sampled high. After that edge both outputs are low. `done_clr` has no effect in any other state.
- R9: The watchdog loads `cfg_wdog` on the wake edge, on the measurement-start edge and on every accepted edge. If no such edge arrives within `cfg_wdog`+1 cycles, the controller returns to hibernation with `osc_en` low and the run count cleared.
- R10: When an accepted or start edge lands in the same cycle as watchdog expiry, the edge wins and the controller keeps going.
- R11: Configuration inputs are captured only while hibernating. Changes made while measuring do not affect the outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on slow clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| comp_in | input | 1 | Asynchronous comparator bit |
| cfg_cycles | input | CNT_W | Number of consecutive accepted periods needed |
| cfg_min_per | input | PER_W | Lower bound of the narrow window, in cycles |
| cfg_max_per | input | PER_W | Upper bound of the narrow window, in cycles |
| cfg_margin | input | PER_W | Hysteresis widening applied to each bound |
| cfg_wdog | input | WD_W | Watchdog reload value |
| done_clr | input | 1 | Host release of the transceiver enable |
| trx_en | output | 1 | Transceiver enable |
| osc_en | output | 1 | Sampling oscillator enable |

## Verification
The collision that matters is watchdog expiry and a qualifying edge landing in the same cycle. The bench provokes it by setting the reload value to exactly one less than the tone period. Every start or accepted edge then arrives on the cycle the counter would expire. The bench judges the result by whether `trx_en` still rises at the expected edge. A companion run uses a reload value one cycle shorter. There, the expected result is `osc_en` falling on the expiry cycle with no wake-up.

// File: rtl/wkup_pkg.sv
package wkup_pkg;

    typedef enum logic [2:0] {
        ST_HIBERNATE = 3'd0,
        ST_SETTLE    = 3'd1,
        ST_ARM       = 3'd2,
        ST_MEASURE   = 3'd3,
        ST_AWAKE     = 3'd4
    } wkup_state_e;

    function automatic logic is_active(input wkup_state_e s);
        return (s == ST_SETTLE) || (s == ST_ARM) || (s == ST_MEASURE);
    endfunction

endpackage

// File: rtl/wkup_sync.sv
module wkup_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= din;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], din};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= chain_q[LAST];
    end

    assign rise = chain_q[LAST] & ~prev_q;

    // a detected edge lasts exactly one cycle
    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise); // R2

endmodule

// File: rtl/wkup_period_meter.sv
module wkup_period_meter #(
    parameter int PER_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic             widen,
    input  logic [PER_W-1:0] min_per,
    input  logic [PER_W-1:0] max_per,
    input  logic [PER_W-1:0] margin,
    output logic             in_win
);
    localparam logic [PER_W-1:0] PER_MAX = '1;
    localparam logic [PER_W-1:0] PER_ONE = PER_W'(1);

    logic [PER_W-1:0] per_q;
    logic [PER_W:0]   hi_sum;
    logic [PER_W-1:0] lo_bound;
    logic [PER_W-1:0] hi_bound;

    // elapsed cycles since the last rising edge, saturating
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          per_q <= '0;
        else if (restart)                    per_q <= PER_ONE;
        else if (run && (per_q != PER_MAX))  per_q <= per_q + PER_ONE;
    end

    // hysteretic bounds
    assign hi_sum = {1'b0, max_per} + {1'b0, margin};

    always_comb begin
        if (widen) begin
            lo_bound = (margin >= min_per) ? '0 : (min_per - margin);
            hi_bound = hi_sum[PER_W] ? PER_MAX : hi_sum[PER_W-1:0];
        end else begin
            lo_bound = min_per;
            hi_bound = max_per;
        end
    end

    assign in_win = (per_q >= lo_bound) && (per_q <= hi_bound);

    AST_PER_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        (per_q == PER_MAX && !restart) |=> per_q == PER_MAX); // R4

    AST_RESTART_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> per_q == PER_ONE); // R4

endmodule

// File: rtl/wkup_watchdog.sv
module wkup_watchdog #(
    parameter int WD_W = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            run,
    input  logic [WD_W-1:0] reload_val,
    output logic            expired
);
    logic [WD_W-1:0] wd_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     wd_q <= '0;
        else if (load)                  wd_q <= reload_val;
        else if (run && (wd_q != '0))   wd_q <= wd_q - WD_W'(1);
    end

    assign expired = run && (wd_q == '0);

    AST_WD_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> wd_q == $past(reload_val)); // R9

    AST_WD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load) |=> $stable(wd_q)); // R9

endmodule

// File: rtl/wkup_validator.sv
module wkup_validator
    import wkup_pkg::*;
#(
    parameter int CNT_W        = 4,
    parameter int PER_W        = 8,
    parameter int WD_W         = 12,
    parameter int SETTLE_TICKS = 4,
    parameter int SYNC_STAGES  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             comp_in,
    input  logic [CNT_W-1:0] cfg_cycles,
    input  logic [PER_W-1:0] cfg_min_per,
    input  logic [PER_W-1:0] cfg_max_per,
    input  logic [PER_W-1:0] cfg_margin,
    input  logic [WD_W-1:0]  cfg_wdog,
    input  logic             done_clr,
    output logic             trx_en,
    output logic             osc_en
);
    localparam int ST_W = (SETTLE_TICKS > 1) ? $clog2(SETTLE_TICKS) : 1;
    localparam logic [ST_W-1:0]  SETTLE_LAST = ST_W'(SETTLE_TICKS - 1);
    localparam logic [CNT_W-1:0] CNT_ONE     = CNT_W'(1);

    wkup_state_e state_q, state_d;

    // configuration captured while hibernating
    logic [CNT_W-1:0] cyc_cfg_q;
    logic [PER_W-1:0] min_cfg_q;
    logic [PER_W-1:0] max_cfg_q;
    logic [PER_W-1:0] mrg_cfg_q;
    logic [WD_W-1:0]  wd_cfg_q;

    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [ST_W-1:0]  settle_q;
    logic [CNT_W-1:0] need;
    logic [CNT_W:0]   cnt_inc;

    logic rise;
    logic in_win;
    logic wd_expired;
    logic wake_ev, start_ev, accept_ev, reach;
    logic wd_load, wd_run, meter_run, settle_done;

    wkup_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (comp_in),
        .rise (rise)
    );

    wkup_period_meter #(.PER_W(PER_W)) u_meter (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (meter_run),
        .restart(rise),
        .widen  (cnt_q != '0),
        .min_per(min_cfg_q),
        .max_per(max_cfg_q),
        .margin (mrg_cfg_q),
        .in_win (in_win)
    );

    wkup_watchdog #(.WD_W(WD_W)) u_wdog (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (wd_load),
        .run       (wd_run),
        .reload_val(wd_cfg_q),
        .expired   (wd_expired)
    );

    // configuration capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_cfg_q <= '0;
            min_cfg_q <= '0;
            max_cfg_q <= '0;
            mrg_cfg_q <= '0;
            wd_cfg_q  <= '0;
        end else if (state_q == ST_HIBERNATE) begin
            cyc_cfg_q <= cfg_cycles;
            min_cfg_q <= cfg_min_per;
            max_cfg_q <= cfg_max_per;
            mrg_cfg_q <= cfg_margin;
            wd_cfg_q  <= cfg_wdog;
        end
    end

    // event decode
    assign need        = (cyc_cfg_q == '0) ? CNT_ONE : cyc_cfg_q;
    assign cnt_inc     = {1'b0, cnt_q} + {1'b0, CNT_ONE};
    assign reach       = cnt_inc >= {1'b0, need};
    assign wake_ev     = (state_q == ST_HIBERNATE) && rise;
    assign start_ev    = (state_q == ST_ARM) && rise;
    assign accept_ev   = (state_q == ST_MEASURE) && rise && in_win;
    assign wd_load     = wake_ev || start_ev || accept_ev;
    assign wd_run      = is_active(state_q);
    assign meter_run   = (state_q == ST_ARM) || (state_q == ST_MEASURE);
    assign settle_done = (settle_q == SETTLE_LAST);

    // settle tick counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                settle_q <= '0;
        else if (wake_ev)                          settle_q <= '0;
        else if (state_q == ST_SETTLE && !settle_done) settle_q <= settle_q + ST_W'(1);
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HIBERNATE: begin
                if (rise) state_d = ST_SETTLE;
            end
            ST_SETTLE: begin
                if (wd_expired)       state_d = ST_HIBERNATE;
                else if (settle_done) state_d = ST_ARM;
            end
            ST_ARM: begin
                if (rise)             state_d = ST_MEASURE;
                else if (wd_expired)  state_d = ST_HIBERNATE;
            end
            ST_MEASURE: begin
                if (accept_ev) begin
                    if (reach) state_d = ST_AWAKE;
                end else if (wd_expired) begin
                    state_d = ST_HIBERNATE;
                end
            end
            ST_AWAKE: begin
                if (done_clr) state_d = ST_HIBERNATE;
            end
            default: state_d = ST_HIBERNATE;
        endcase
    end

    // consecutive-period run count
    always_comb begin
        cnt_d = cnt_q;
        unique case (state_q)
            ST_HIBERNATE, ST_SETTLE, ST_ARM: cnt_d = '0;
            ST_MEASURE: begin
                if (accept_ev)       cnt_d = cnt_inc[CNT_W-1:0];
                else if (rise)       cnt_d = '0;
                else if (wd_expired) cnt_d = '0;
            end
            ST_AWAKE: begin
                if (done_clr) cnt_d = '0;
            end
            default: cnt_d = '0;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HIBERNATE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trx_en <= 1'b0;
            osc_en <= 1'b0;
        end else begin
            trx_en <= (state_d == ST_AWAKE);
            osc_en <= is_active(state_d);
        end
    end

    AST_WAKE_OSC: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HIBERNATE && rise) |=> osc_en); // R2

    AST_HIB_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HIBERNATE) |-> (!osc_en && !trx_en)); // R1

    AST_EN_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(trx_en && osc_en)); // R7

    AST_CNT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= need); // R7

    AST_MISS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MEASURE && rise && !in_win) |=> cnt_q == '0); // R6

    AST_TRX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (trx_en && !done_clr) |=> trx_en); // R8

    AST_DONE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (trx_en && done_clr) |=> (!trx_en && !osc_en)); // R8

    AST_WD_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_expired && !wd_load) |=> (state_q == ST_HIBERNATE && cnt_q == '0)); // R9

    AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_expired && wd_load) |=> (osc_en || trx_en)); // R10

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARM || state_q == ST_MEASURE) |=> $stable(cyc_cfg_q)); // R11

endmodule

// File: tb/wkup_validator_tb_top.sv
module wkup_validator_tb_top;

    localparam int CLK_P  = 10;
    localparam int SETTLE = 4;

    typedef int gap_t [8];

    typedef struct {
        int    cyc;
        logic  trx;
        logic  osc;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       comp_in = 1'b0;
    logic [3:0] cfg_cycles = '0;
    logic [7:0] cfg_min_per = '0;
    logic [7:0] cfg_max_per = '0;
    logic [7:0] cfg_margin = '0;
    logic [11:0] cfg_wdog = '0;
    logic       done_clr = 1'b0;
    logic       trx_en;
    logic       osc_en;

    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    bit   finished = 0;
    exp_t exp_q[$];

    wkup_validator dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .comp_in    (comp_in),
        .cfg_cycles (cfg_cycles),
        .cfg_min_per(cfg_min_per),
        .cfg_max_per(cfg_max_per),
        .cfg_margin (cfg_margin),
        .cfg_wdog   (cfg_wdog),
        .done_clr   (done_clr),
        .trx_en     (trx_en),
        .osc_en     (osc_en)
    );

    always #(CLK_P/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // scoreboard driver side: sorted insert
    task automatic push_exp(input int c, input logic t, input logic o, input string tag);
        exp_t e;
        int   idx;
        e.cyc = c; e.trx = t; e.osc = o; e.tag = tag;
        idx = exp_q.size();
        for (int i = 0; i < exp_q.size(); i++) begin
            if (exp_q[i].cyc > c) begin idx = i; break; end
        end
        exp_q.insert(idx, e);
    endtask

    // scoreboard monitor side
    always @(negedge clk) begin
        while (exp_q.size() > 0 && exp_q[0].cyc <= cyc) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (e.cyc != cyc || trx_en !== e.trx || osc_en !== e.osc) begin
                errors++;
                $display("FAIL %s cyc=%0d: actual trx_en=%b osc_en=%b expected trx_en=%b osc_en=%b (due cyc %0d)",
                         e.tag, cyc, trx_en, osc_en, e.trx, e.osc, e.cyc);
            end
        end
    end

    task automatic release_trx();
        int c;
        c = cyc;
        push_exp(c + 1, 1'b1, 1'b0, "R8 hold");
        push_exp(c + 2, 1'b1, 1'b0, "R8 hold");
        repeat (2) @(negedge clk);
        done_clr = 1'b1;
        push_exp(c + 3, 1'b0, 1'b0, "R8 clear");
        @(negedge clk);
        done_clr = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // drive a tone of rise gaps; predict the outcome from the requirements
    task automatic run_tone(input gap_t g, input bit disturb, input string tag);
        int r0, t, last, lastld, cnt, need, lo, hi, wake, expd, ndrive, start_idx, p, wd, target;
        bit started, reload, hit;
        logic [3:0] sv_cyc;
        logic [7:0] sv_min;
        sv_cyc = cfg_cycles; sv_min = cfg_min_per;
        r0 = cyc + 3;
        need = (cfg_cycles == 0) ? 1 : int'(cfg_cycles);
        wd = int'(cfg_wdog);
        cnt = 0; started = 0; lastld = r0; wake = -1; expd = -1;
        t = r0; ndrive = 1; start_idx = -1; last = 0;
        for (int i = 0; i < 8; i++) begin
            if (g[i] == 0 || wake >= 0 || expd >= 0) break;
            t += g[i]; reload = 0; hit = 0;
            if (t - r0 > SETTLE) begin
                if (!started) begin
                    started = 1; reload = 1; start_idx = i + 1;
                end else begin
                    p = t - last;
                    if (cnt == 0) begin
                        lo = int'(cfg_min_per); hi = int'(cfg_max_per);
                    end else begin
                        lo = int'(cfg_min_per) - int'(cfg_margin); if (lo < 0) lo = 0;
                        hi = int'(cfg_max_per) + int'(cfg_margin); if (hi > 255) hi = 255;
                    end
                    if (p >= lo && p <= hi) begin
                        cnt++; reload = 1;
                        if (cnt >= need) hit = 1;
                    end else cnt = 0;
                end
                last = t;
            end
            if (t > lastld + wd + 1 || (t == lastld + wd + 1 && !reload))
                expd = lastld + wd + 1;
            else begin
                ndrive = i + 2;
                if (reload) lastld = t;
                if (hit) wake = t;
            end
        end
        if (wake < 0 && expd < 0) expd = lastld + wd + 1;

        push_exp(r0 - 1, 1'b0, 1'b0, "R2 before wake");
        push_exp(r0,     1'b0, 1'b1, "R2 wake");
        if (wake >= 0) begin
            push_exp(wake - 1, 1'b0, 1'b1, tag);
            push_exp(wake,     1'b1, 1'b0, tag);
        end else begin
            push_exp(expd - 1, 1'b0, 1'b1, tag);
            push_exp(expd,     1'b0, 1'b0, tag);
        end

        for (int i = 0; i < ndrive; i++) begin
            if (i > 0) begin
                @(negedge clk);
                done_clr = 1'b0;
                repeat (g[i-1] - 2) @(negedge clk);
            end
            comp_in = 1'b1;
            @(negedge clk);
            comp_in = 1'b0;
            if (disturb && i == start_idx) begin
                cfg_cycles = 4'd15;
                cfg_min_per = 8'd30;
                done_clr = 1'b1;
            end
        end
        target = ((wake >= 0) ? wake : expd) + 1;
        while (cyc < target) begin
            @(negedge clk);
            done_clr = 1'b0;
        end
        done_clr = 1'b0;
        if (disturb) begin cfg_cycles = sv_cyc; cfg_min_per = sv_min; end
        if (wake >= 0) release_trx();
        repeat (3) @(negedge clk);
    endtask

    task automatic set_cfg(input int n, input int mn, input int mx, input int m, input int w);
        cfg_cycles = 4'(n); cfg_min_per = 8'(mn); cfg_max_per = 8'(mx);
        cfg_margin = 8'(m); cfg_wdog = 12'(w);
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: run hung at cyc=%0d", cyc);
            report();
            $finish;
        end
    end

    initial begin
        // R1: reset state
        push_exp(1, 1'b0, 1'b0, "R1 reset");
        push_exp(2, 1'b0, 1'b0, "R1 reset");
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        push_exp(5, 1'b0, 1'b0, "R1 idle");
        repeat (4) @(negedge clk);

        // R4 R7: steady in-window tone
        set_cfg(3, 8, 12, 2, 200);
        run_tone('{6, 10, 10, 10, 0, 0, 0, 0}, 0, "R4 R7 basic wake");

        // R5: hysteresis, upper drift
        set_cfg(3, 8, 10, 3, 200);
        run_tone('{6, 12, 12, 10, 12, 13, 0, 0}, 0, "R5 widen high");
        // R5: hysteresis, lower drift
        run_tone('{6, 9, 6, 5, 0, 0, 0, 0}, 0, "R5 widen low");

        // R6: misses clear the run
        set_cfg(3, 8, 10, 0, 200);
        run_tone('{6, 9, 9, 15, 9, 9, 9, 0}, 0, "R6 long miss");
        run_tone('{6, 9, 5, 9, 9, 9, 0, 0}, 0, "R6 short miss");

        // R9: never qualifies, watchdog returns to hibernation
        set_cfg(2, 8, 10, 0, 60);
        run_tone('{6, 20, 20, 0, 0, 0, 0, 0}, 0, "R9 expiry");

        // R3: edge during settle ignored
        set_cfg(1, 8, 12, 0, 200);
        run_tone('{4, 10, 10, 0, 0, 0, 0, 0}, 0, "R3 settle");

        // R10: edge lands on the expiry cycle
        set_cfg(2, 8, 12, 0, 9);
        run_tone('{6, 10, 10, 0, 0, 0, 0, 0}, 0, "R10 edge wins");
        set_cfg(2, 8, 12, 0, 8);
        run_tone('{6, 10, 10, 0, 0, 0, 0, 0}, 0, "R9 R10 expiry first");

        // R11 and R8: config changes and done_clr while measuring have no effect
        set_cfg(2, 8, 12, 0, 200);
        run_tone('{6, 10, 10, 0, 0, 0, 0, 0}, 1, "R11 frozen config");

        // R7: zero target acts as one
        set_cfg(0, 8, 12, 0, 200);
        run_tone('{6, 10, 0, 0, 0, 0, 0, 0}, 0, "R7 zero target");

        repeat (5) @(negedge clk);
        while (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++; errors++;
            $display("FAIL %s: expectation at cyc %0d never checked", e.tag, e.cyc);
        end
        finished = 1;
        report();
        $finish;
    end

endmodule